// File: doc/BRIEF.md
# Linear CCD Drive-Clock Sequencer

This block produces the five clock and gate lines that a linear CCD image sensor needs: two shift phases, a read gate that resets the output node, a clamp, and a transfer gate that moves the exposed line into the sensor's shift register. It accepts two one-cycle commands. A pixel-shift command runs a short fixed pattern that brings the next cell to the sensor output. A transfer command runs a longer settle–transfer–settle pattern that loads a fresh line.

Every step of a pattern is held for a parameterised number of system clock cycles. Each pin's active level is set by a per-bit polarity mask, which is XORed onto the logical drive word. When a pattern ends, the block raises a one-cycle completion pulse. After a shift, a separate pulse says that the cell now on the sensor output is valid to sample. Between commands the pins hold the last resting level of the pattern that ran. A sampling converter and an accumulator outside the block use these pulses to pace their reads.

Top module: `ccd_clk_seq`

## Requirements
- R1: During and after reset, until the first accepted command, `pins_o` equals `POL_MASK` (all lines inactive; default 7'h50), and `busy_o`, `done_o` and `pix_valid_o` are 0.
- R2: The logical word `pins_o ^ POL_MASK` uses bit 0 for phase 2, bit 1 for phase 1, bit 4 for clamp, bit 5 for read gate and bit 6 for transfer gate. Bits 2 and 3 always stay at their mask value.
- R3: An accepted shift command drives the following logical words, starting at the accepting edge: 7'h02 for GAP_CYC cycles, 7'h22 for RG_CYC cycles, 7'h02 for GAP_CYC, 7'h12 for CL_CYC, 7'h02 for GAP_CYC, then 7'h01.
- R4: When a shift ends, the word becomes 7'h01 in the same cycle that `done_o` and `pix_valid_o` are high, each for exactly one cycle. While idle, the pins hold their resting word unchanged.
- R5: An accepted transfer command drives 7'h02 for SETTLE_CYC cycles, 7'h42 for XFER_CYC cycles and 7'h02 for POST_CYC cycles. It then rests at 7'h02 with a one-cycle `done_o`, while `pix_valid_o` stays 0.
- R6: `busy_o` is high from the accepting edge until the edge where `done_o` rises, and is low in that `done_o` cycle.
- R7: A start command raised while `busy_o` is high, or in the last step of a pattern, is ignored and does not change the pattern's timing.
- R8: If both commands are raised together while idle, the transfer is run.
- R9: Phase 1 and phase 2 are never active together, and at most one of clamp, read gate and transfer gate is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_go_i | input | 1 | Request a one-pixel shift pattern |
| xfer_go_i | input | 1 | Request a line transfer pattern |
| pins_o | output | 7 | Sensor drive word after the polarity mask |
| busy_o | output | 1 | A pattern is running |
| done_o | output | 1 | One-cycle pulse when a pattern ends |
| pix_valid_o | output | 1 | One-cycle pulse when a shift ends and the output cell is valid |

## Verification
A wrong step state or a wrong step counter changes the logical pin word in the cycle it goes wrong. The bench compares the full word against the expected step on every cycle of every pattern, so a wrong step or step length appears within one cycle. A wrong resting state or a lost completion shows in the cycle the pattern should end, through `busy_o`, `done_o`, `pix_valid_o` and the resting word. A start that is taken by mistake during a pattern shows as a word mismatch one cycle later.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   localparam int PORT_W    = 7;
   localparam int PIN_PH2   = 0;
   localparam int PIN_PH1   = 1;
   localparam int PIN_CLAMP = 4;
   localparam int PIN_RDG   = 5;
   localparam int PIN_XFER  = 6;

   localparam logic [PORT_W-1:0] USED_PINS =
      PORT_W'((1 << PIN_PH2) | (1 << PIN_PH1) | (1 << PIN_CLAMP) |
              (1 << PIN_RDG) | (1 << PIN_XFER));

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SH_LEAD,
      ST_SH_RDG,
      ST_SH_MID,
      ST_SH_CLAMP,
      ST_SH_TAIL,
      ST_TR_SETTLE,
      ST_TR_GATE,
      ST_TR_POST
   } seq_st_e;

   typedef enum logic [1:0] {
      REST_OFF,
      REST_PH2,
      REST_PH1
   } rest_e;

   // Logical (active-high) drive word for a step, before the polarity mask.
   function automatic logic [PORT_W-1:0] step_word(seq_st_e st, rest_e rs);
      logic [PORT_W-1:0] w;
      w = '0;
      unique case (st)
         ST_IDLE: begin
            if (rs == REST_PH2) w[PIN_PH2] = 1'b1;
            else if (rs == REST_PH1) w[PIN_PH1] = 1'b1;
         end
         ST_SH_RDG: begin
            w[PIN_PH1] = 1'b1;
            w[PIN_RDG] = 1'b1;
         end
         ST_SH_CLAMP: begin
            w[PIN_PH1]   = 1'b1;
            w[PIN_CLAMP] = 1'b1;
         end
         ST_TR_GATE: begin
            w[PIN_PH1]  = 1'b1;
            w[PIN_XFER] = 1'b1;
         end
         default: w[PIN_PH1] = 1'b1;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ccd_step_timer.sv
module ccd_step_timer #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
   import ccd_seq_pkg::*;
#(
   parameter int CW         = 8,
   parameter int GAP_CYC    = 1,
   parameter int RG_CYC     = 3,
   parameter int CL_CYC     = 3,
   parameter int SETTLE_CYC = 16,
   parameter int XFER_CYC   = 160,
   parameter int POST_CYC   = 24
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    shift_go_i,
   input  logic    xfer_go_i,
   input  logic    tm_zero_i,
   output logic    tm_load_o,
   output logic [CW-1:0] tm_val_o,
   output seq_st_e st_q_o,
   output seq_st_e st_nxt_o,
   output rest_e   rest_q_o,
   output rest_e   rest_nxt_o,
   output logic    done_o,
   output logic    pix_valid_o
);

   localparam logic [CW-1:0] L_GAP    = CW'(GAP_CYC - 1);
   localparam logic [CW-1:0] L_RG     = CW'(RG_CYC - 1);
   localparam logic [CW-1:0] L_CL     = CW'(CL_CYC - 1);
   localparam logic [CW-1:0] L_SETTLE = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] L_XFER   = CW'(XFER_CYC - 1);
   localparam logic [CW-1:0] L_POST   = CW'(POST_CYC - 1);

   seq_st_e st_q, st_d;
   rest_e   rest_q, rest_d;
   logic    fin_sh, fin_tr;
   logic    done_q, pix_q;

   always_comb begin
      st_d      = st_q;
      rest_d    = rest_q;
      tm_load_o = 1'b0;
      tm_val_o  = '0;
      fin_sh    = 1'b0;
      fin_tr    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (xfer_go_i) begin
               st_d = ST_TR_SETTLE; tm_load_o = 1'b1; tm_val_o = L_SETTLE;
            end else if (shift_go_i) begin
               st_d = ST_SH_LEAD;   tm_load_o = 1'b1; tm_val_o = L_GAP;
            end
         end
         ST_SH_LEAD:   if (tm_zero_i) begin st_d = ST_SH_RDG;   tm_load_o = 1'b1; tm_val_o = L_RG;   end
         ST_SH_RDG:    if (tm_zero_i) begin st_d = ST_SH_MID;   tm_load_o = 1'b1; tm_val_o = L_GAP;  end
         ST_SH_MID:    if (tm_zero_i) begin st_d = ST_SH_CLAMP; tm_load_o = 1'b1; tm_val_o = L_CL;   end
         ST_SH_CLAMP:  if (tm_zero_i) begin st_d = ST_SH_TAIL;  tm_load_o = 1'b1; tm_val_o = L_GAP;  end
         ST_SH_TAIL:   if (tm_zero_i) begin st_d = ST_IDLE; rest_d = REST_PH2; fin_sh = 1'b1; end
         ST_TR_SETTLE: if (tm_zero_i) begin st_d = ST_TR_GATE;  tm_load_o = 1'b1; tm_val_o = L_XFER; end
         ST_TR_GATE:   if (tm_zero_i) begin st_d = ST_TR_POST;  tm_load_o = 1'b1; tm_val_o = L_POST; end
         ST_TR_POST:   if (tm_zero_i) begin st_d = ST_IDLE; rest_d = REST_PH1; fin_tr = 1'b1; end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         rest_q <= REST_OFF;
         done_q <= 1'b0;
         pix_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         rest_q <= rest_d;
         done_q <= fin_sh | fin_tr;
         pix_q  <= fin_sh;
      end
   end

   assign st_q_o      = st_q;
   assign st_nxt_o    = st_d;
   assign rest_q_o    = rest_q;
   assign rest_nxt_o  = rest_d;
   assign done_o      = done_q;
   assign pix_valid_o = pix_q;

endmodule

// File: rtl/ccd_pin_stage.sv
module ccd_pin_stage
   import ccd_seq_pkg::*;
#(
   parameter logic [PORT_W-1:0] POL_MASK = 7'h50,
   parameter bit                REG_OUT  = 1'b1
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  seq_st_e st_i,
   input  rest_e   rest_i,
   output logic [PORT_W-1:0] pins_o
);

   if (REG_OUT) begin : g_reg
      // st_i/rest_i carry the next state: the flop lands with the state.
      logic [PORT_W-1:0] pins_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) pins_q <= POL_MASK;
         else         pins_q <= step_word(st_i, rest_i) ^ POL_MASK;
      end
      assign pins_o = pins_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign pins_o = step_word(st_i, rest_i) ^ POL_MASK;
   end

endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
   import ccd_seq_pkg::*;
#(
   parameter logic [6:0] POL_MASK   = 7'h50,
   parameter bit         REG_OUT    = 1'b1,
   parameter int         GAP_CYC    = 1,
   parameter int         RG_CYC     = 3,
   parameter int         CL_CYC     = 3,
   parameter int         SETTLE_CYC = 16,
   parameter int         XFER_CYC   = 160,
   parameter int         POST_CYC   = 24
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       shift_go_i,
   input  logic       xfer_go_i,
   output logic [6:0] pins_o,
   output logic       busy_o,
   output logic       done_o,
   output logic       pix_valid_o
);

   localparam int M_SH  = (GAP_CYC > RG_CYC) ? GAP_CYC : RG_CYC;
   localparam int M_SH2 = (M_SH > CL_CYC) ? M_SH : CL_CYC;
   localparam int M_TR  = (SETTLE_CYC > XFER_CYC) ? SETTLE_CYC : XFER_CYC;
   localparam int M_TR2 = (M_TR > POST_CYC) ? M_TR : POST_CYC;
   localparam int MAXC  = (M_SH2 > M_TR2) ? M_SH2 : M_TR2;
   localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;

   if (GAP_CYC < 1 || RG_CYC < 1 || CL_CYC < 1 ||
       SETTLE_CYC < 1 || XFER_CYC < 1 || POST_CYC < 1) begin : g_bad_len
      $error("ccd_clk_seq: every step length must be at least one cycle");
   end
   if ((POL_MASK & ~USED_PINS) != '0) begin : g_bad_mask
      $error("ccd_clk_seq: polarity mask sets an unused pin");
   end

   logic          tm_load, tm_zero;
   logic [CW-1:0] tm_val;
   seq_st_e       st_q, st_nxt, st_sel;
   rest_e         rest_q, rest_nxt, rest_sel;

   ccd_step_timer #(.CW(CW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tm_load),
      .val_i  (tm_val),
      .zero_o (tm_zero)
   );

   ccd_seq_fsm #(
      .CW(CW), .GAP_CYC(GAP_CYC), .RG_CYC(RG_CYC), .CL_CYC(CL_CYC),
      .SETTLE_CYC(SETTLE_CYC), .XFER_CYC(XFER_CYC), .POST_CYC(POST_CYC)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .shift_go_i  (shift_go_i),
      .xfer_go_i   (xfer_go_i),
      .tm_zero_i   (tm_zero),
      .tm_load_o   (tm_load),
      .tm_val_o    (tm_val),
      .st_q_o      (st_q),
      .st_nxt_o    (st_nxt),
      .rest_q_o    (rest_q),
      .rest_nxt_o  (rest_nxt),
      .done_o      (done_o),
      .pix_valid_o (pix_valid_o)
   );

   if (REG_OUT) begin : g_sel_next
      assign st_sel   = st_nxt;
      assign rest_sel = rest_nxt;
   end else begin : g_sel_cur
      assign st_sel   = st_q;
      assign rest_sel = rest_q;
   end

   ccd_pin_stage #(.POL_MASK(POL_MASK), .REG_OUT(REG_OUT)) u_pins (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .st_i   (st_sel),
      .rest_i (rest_sel),
      .pins_o (pins_o)
   );

   assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/ccd_clk_seq_chk.sv
module ccd_clk_seq_chk #(
   parameter logic [6:0] POL_MASK = 7'h50
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [6:0] pins_o,
   input logic       busy_o,
   input logic       done_o,
   input logic       pix_valid_o
);

   logic [6:0] act;
   assign act = pins_o ^ POL_MASK;

   assert_spare_pins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act[3:2] == 2'b00);

   assert_phase_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(act[0] && act[1]) && ($countones(act[6:4]) <= 1));

   assert_gate_rides_ph1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act[4] || act[5]) |-> (act[1] && busy_o));

   assert_xfer_rides_ph1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act[6] |-> (act[1] && busy_o));

   assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_pix_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pix_valid_o |-> (done_o && act == 7'h01));

   assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);

   assert_rest_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !done_o && $past(!busy_o)) |-> $stable(pins_o));

endmodule

bind ccd_clk_seq ccd_clk_seq_chk #(.POL_MASK(POL_MASK)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pins_o      (pins_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .pix_valid_o (pix_valid_o)
);

// File: tb/tb_ccd_clk_seq.sv
module tb_ccd_clk_seq;

   localparam logic [6:0] MASK = 7'h50;
   localparam int GAP = 1, RG = 3, CL = 3, SET = 16, XF = 160, PST = 24;
   localparam int SH_LEN = 3*GAP + RG + CL;
   localparam int TR_LEN = SET + XF + PST;
   localparam logic [6:0] W_P1 = 7'h02, W_P2 = 7'h01;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shift_go = 1'b0, xfer_go = 1'b0;
   logic [6:0] pins;
   logic busy, done, pix;

   int n_chk = 0, n_fail = 0;
   logic [6:0] rest_w = 7'h00;

   always #5 clk = ~clk;

   ccd_clk_seq #(
      .POL_MASK(MASK), .REG_OUT(1'b1), .GAP_CYC(GAP), .RG_CYC(RG), .CL_CYC(CL),
      .SETTLE_CYC(SET), .XFER_CYC(XF), .POST_CYC(PST)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .shift_go_i(shift_go), .xfer_go_i(xfer_go),
      .pins_o(pins), .busy_o(busy), .done_o(done), .pix_valid_o(pix)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   function automatic logic [6:0] exp_word(input bit is_tr, input int t);
      if (is_tr) begin
         if (t < SET) return W_P1;
         if (t < SET + XF) return 7'h42;
         return W_P1;
      end
      if (t < GAP) return W_P1;
      if (t < GAP + RG) return 7'h22;
      if (t < 2*GAP + RG) return W_P1;
      if (t < 2*GAP + RG + CL) return 7'h12;
      if (t < SH_LEN) return W_P1;
      return W_P2;
   endfunction

   // Called at a falling edge; the command is latched at the next rising edge.
   task automatic run_cmd(input bit sh, input bit tr, input bit noise);
      int T;
      bit is_tr;
      logic [6:0] a, e;
      is_tr = tr;                      // R8: transfer wins when both are raised
      T = is_tr ? TR_LEN : SH_LEN;
      shift_go = sh;
      xfer_go  = tr;
      for (int t = 0; t <= T; t++) begin
         @(negedge clk);
         if (t < T && noise) begin     // R7: starts during a pattern are ignored
            shift_go = 1'($urandom_range(0, 1));
            xfer_go  = 1'($urandom_range(0, 1));
         end else begin
            shift_go = 1'b0;
            xfer_go  = 1'b0;
         end
         a = pins ^ MASK;
         e = exp_word(is_tr, t);
         chk(a == e, is_tr ? (noise ? "R5/R7 word" : "R5 word") : (noise ? "R3/R7 word" : "R3 word"), 32'(a), 32'(e));
         chk(a[3:2] == 2'b00, "R2 spare bits", 32'(a[3:2]), 0);
         chk(!(a[0] && a[1]) && ($countones(a[6:4]) <= 1), "R9 exclusive lines", 32'(a), 32'(e));
         chk(busy == (t < T), "R6 busy", 32'(busy), 32'(t < T));
         chk(done == (t == T), "R4 done", 32'(done), 32'(t == T));
         chk(pix == (t == T && !is_tr), is_tr ? "R5 no pix" : "R4 pix", 32'(pix), 32'(t == T && !is_tr));
      end
      rest_w = is_tr ? W_P1 : W_P2;
   endtask

   task automatic idle_gap(input int g);
      for (int i = 0; i < g; i++) begin
         @(negedge clk);
         chk((pins ^ MASK) == rest_w, "R4 rest hold", 32'(pins ^ MASK), 32'(rest_w));
         chk(!done && !busy && !pix, "R4 no pulse idle", 32'({busy, done, pix}), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int seed;
      int kind;
      seed = $urandom(32'd1357);
      repeat (3) @(negedge clk);
      chk(pins == MASK, "R1 reset pins", 32'(pins), 32'(MASK));
      chk(!busy && !done && !pix, "R1 reset flags", 32'({busy, done, pix}), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(pins == MASK, "R1 idle after reset", 32'(pins), 32'(MASK));
      chk(!busy && !done && !pix, "R1 idle flags", 32'({busy, done, pix}), 0);

      run_cmd(1'b1, 1'b0, 1'b0);  idle_gap(2);   // R3 plain shift
      run_cmd(1'b0, 1'b1, 1'b0);                 // R5 transfer, back to back
      run_cmd(1'b1, 1'b1, 1'b0);  idle_gap(1);   // R8 simultaneous
      run_cmd(1'b1, 1'b0, 1'b1);                 // R7 noise during shift
      run_cmd(1'b0, 1'b1, 1'b1);  idle_gap(3);   // R7 noise during transfer

      for (int n = 0; n < 40; n++) begin
         kind = int'($urandom_range(0, 2));
         run_cmd(kind != 1, kind != 0, 1'($urandom_range(0, 1)));
         idle_gap(int'($urandom_range(0, 3)));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule